// File: doc/BRIEF.md
# Burst Write Controller from FIFO to Shared SRAM Port

This block moves one block of 32-bit words out of a synchronous show-ahead FIFO and writes it into a shared dual-port SRAM. It masters a slave-style synchronous local bus. A rising edge on the `go` input captures a start address and a word count. The block then issues one address phase and streams the words, one per clock, while both the FIFO and the bus keep up.

The sequencing is done by a seven-phase state machine. The phases are idle, address, wait-for-data, fetch, stream, final-word and done. A FIFO that runs dry stops the burst. A bus that is not ready also stops it. Neither stall loses or repeats a word, and neither reissues the address. A down-counter tracks how many words remain. It closes the burst by marking the final data word with a burst-last line. After the burst, the block waits in the done phase until `go` is released. Only a fresh rising edge starts the next block.

Top module: `burst_wr_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until a transfer starts, `bus_sel`, `bus_stb`, `bus_wr`, `bus_last` and `fifo_rd` are all 0.
- R2: Only a 0-to-1 transition of `go` starts a transfer. A `go` that is already high when reset is released starts nothing.
- R3: The first cycle with `bus_sel` high is the address phase. It lasts exactly one cycle and does not wait for `bus_ready`. In it, `bus_stb` and `bus_wr` are 1 and `bus_addr` equals the `base_addr` sampled at the start edge.
- R4: `fifo_rd` is never 1 while `fifo_empty` is 1. The block writes exactly `burst_len` words, in FIFO order. A `burst_len` of 0 writes one word.
- R5: A data word is transferred in each cycle after the address phase where `bus_stb`=1 and `bus_ready`=1. With a FIFO already holding the block and `bus_ready` held at 1, the first word goes 3 cycles after the address phase and the rest follow on consecutive cycles.
- R6: While a data word is presented and `bus_ready` is 0, `bus_data` and `bus_last` hold their values into the next cycle.
- R7: A mid-burst FIFO underflow lowers `bus_stb` until data returns. It does not lower `bus_sel` or repeat the address phase, so each burst has exactly one address phase.
- R8: `bus_last` is 1 only while the final word of the burst is presented. Exactly one transferred word carries it.
- R9: After the final word, `bus_sel` falls. The block stays idle while `go` remains 1, and it starts again only after `go` falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start level; its rising edge begins one block |
| base_addr | input | AW (12) | SRAM start address, sampled at the start edge |
| burst_len | input | LW (12) | Words in the block, sampled at the start edge (0 means 1) |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rdata | input | DW (32) | Head word of the show-ahead FIFO |
| fifo_rd | output | 1 | Pop the FIFO head at this clock edge |
| bus_ready | input | 1 | SRAM port accepts a data word this cycle |
| bus_sel | output | 1 | Bus selected for the duration of a burst |
| bus_stb | output | 1 | Address or data presented this cycle |
| bus_wr | output | 1 | Write direction, high with select |
| bus_last | output | 1 | Final word of the burst is presented |
| bus_addr | output | AW (12) | Burst start address |
| bus_data | output | DW (32) | Write data word |

## Verification
The main function is driven by eight bursts that combine three conditions: a FIFO filled beforehand or fed slowly, a bus that is always ready or periodically not ready, and lengths from 1 to 30. A filled FIFO with an always-ready bus shows the one-word-per-clock streaming and the fixed three-cycle lead-in. A slowly fed FIFO shows that an underflow leaves select and the single address phase intact. The not-ready patterns show that a stalled word is held and is neither lost nor repeated. Directed cases cover a zero length, a `go` held through reset, and a `go` held high after completion, which must not restart the block.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_ADDR   = 3'd1,
      PH_WAITF  = 3'd2,
      PH_FETCH  = 3'd3,
      PH_STREAM = 3'd4,
      PH_FINAL  = 3'd5,
      PH_DONE   = 3'd6
   } phase_e;
endpackage

// File: rtl/bwc_len_ctr.sv
module bwc_len_ctr #(
   parameter int LW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [LW-1:0] len_in,
   input  logic          dec,
   output logic          cnt_one,
   output logic          cnt_two
);
   localparam logic [LW-1:0] ONE = LW'(1);
   localparam logic [LW-1:0] TWO = LW'(2);

   logic [LW-1:0] cnt_q;
   logic [LW-1:0] load_val;

   initial assert (LW >= 2) else $error("LW must be at least 2");

   assign load_val = (len_in == '0) ? ONE : len_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (dec)  cnt_q <= cnt_q - ONE;
   end

   assign cnt_one = (cnt_q == ONE);
   assign cnt_two = (cnt_q == TWO);

   // R4: a transfer never happens with no word left
   assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt_q != '0));
endmodule

// File: rtl/bwc_word_hold.sv
module bwc_word_hold #(
   parameter int DW         = 32,
   parameter bit RESET_HOLD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   initial assert (DW >= 1) else $error("DW must be positive");

   generate
      if (RESET_HOLD) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= '0;
            else if (ld) q <= d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (ld) q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/bwc_phase_fsm.sv
module bwc_phase_fsm
   import bwc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_edge,
   input  logic   go_lvl,
   input  logic   fifo_empty,
   input  logic   bus_ready,
   input  logic   cnt_one,
   input  logic   cnt_two,
   output phase_e ph_q
);
   phase_e ph_d;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE:   if (start_edge) ph_d = PH_ADDR;
         PH_ADDR:   ph_d = PH_WAITF;
         PH_WAITF:  if (!fifo_empty) ph_d = PH_FETCH;
         PH_FETCH:  ph_d = cnt_one ? PH_FINAL : PH_STREAM;
         PH_STREAM: begin
            if (!bus_ready)     ph_d = PH_STREAM;
            else if (fifo_empty) ph_d = PH_WAITF;
            else if (cnt_two)    ph_d = PH_FINAL;
            else                 ph_d = PH_STREAM;
         end
         PH_FINAL:  if (bus_ready) ph_d = PH_DONE;
         PH_DONE:   if (!go_lvl) ph_d = PH_IDLE;
         default:   ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   // R3: the address phase is a single cycle
   assert_addr_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_ADDR) |=> (ph_q == PH_WAITF));
   // R9: done is held while the start level stays high
   assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DONE && go_lvl) |=> (ph_q == PH_DONE));
endmodule

// File: rtl/burst_wr_ctrl.sv
module burst_wr_ctrl
   import bwc_pkg::*;
#(
   parameter int DW         = 32,
   parameter int AW         = 12,
   parameter int LW         = 12,
   parameter bit RESET_HOLD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] base_addr,
   input  logic [LW-1:0] burst_len,
   input  logic          fifo_empty,
   input  logic [DW-1:0] fifo_rdata,
   output logic          fifo_rd,
   input  logic          bus_ready,
   output logic          bus_sel,
   output logic          bus_stb,
   output logic          bus_wr,
   output logic          bus_last,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_data
);
   initial assert (AW >= 1) else $error("AW must be positive");

   phase_e        ph_q;
   logic          go_q;
   logic          start_edge;
   logic          start_load;
   logic          in_data;
   logic          xfer;
   logic          cnt_one;
   logic          cnt_two;
   logic [AW-1:0] addr_q;

   // go_q resets high so a level held through reset is not an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) go_q <= 1'b1;
      else        go_q <= go;
   end

   assign start_edge = go && !go_q;
   assign start_load = start_edge && (ph_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          addr_q <= '0;
      else if (start_load) addr_q <= base_addr;
   end

   assign in_data  = (ph_q == PH_STREAM) || (ph_q == PH_FINAL);
   assign xfer     = in_data && bus_ready;
   assign bus_sel  = (ph_q == PH_ADDR) || (ph_q == PH_WAITF) ||
                     (ph_q == PH_FETCH) || in_data;
   assign bus_wr   = bus_sel;
   assign bus_stb  = (ph_q == PH_ADDR) || in_data;
   assign bus_last = (ph_q == PH_FINAL);
   assign bus_addr = addr_q;
   assign fifo_rd  = (ph_q == PH_FETCH) ||
                     ((ph_q == PH_STREAM) && bus_ready && !fifo_empty);

   bwc_phase_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_edge (start_edge),
      .go_lvl     (go),
      .fifo_empty (fifo_empty),
      .bus_ready  (bus_ready),
      .cnt_one    (cnt_one),
      .cnt_two    (cnt_two),
      .ph_q       (ph_q)
   );

   bwc_len_ctr #(.LW(LW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_load),
      .len_in  (burst_len),
      .dec     (xfer),
      .cnt_one (cnt_one),
      .cnt_two (cnt_two)
   );

   bwc_word_hold #(.DW(DW), .RESET_HOLD(RESET_HOLD)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (fifo_rd),
      .d     (fifo_rdata),
      .q     (bus_data)
   );

   // R4: no pop from an empty FIFO
   assert_rd_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> !fifo_empty);
   // R6: a stalled data word and its last flag are held
   assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && !bus_ready) |=> ($stable(bus_data) && $stable(bus_last)));
   // R8: last only with a presented word and one word remaining
   assert_last_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_last |-> (bus_stb && bus_sel && cnt_one));
   // R2: idle without a rising edge stays idle
   assert_edge_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_IDLE && !start_edge) |=> (ph_q == PH_IDLE));
   // R7: select stays high from address phase until the final word
   assert_sel_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_last) |=> bus_sel);
endmodule

// File: tb/test_burst_wr_ctrl.sv
module test_burst_wr_ctrl;
   localparam int  DW = 32;
   localparam int  AW = 12;
   localparam int  LW = 12;
   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC = 8;
   // len, ready period (0 = always), feed gap (0 = prefilled), address
   localparam int VEC [NVEC][4] = '{
      '{1,  0, 0, 'h010}, '{2,  0, 0, 'h020}, '{8,  0, 0, 'h100},
      '{16, 3, 0, 'h200}, '{12, 0, 3, 'h300}, '{20, 4, 2, 'h7F0},
      '{3,  2, 0, 'h001}, '{30, 5, 4, 'hABC}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          go = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [LW-1:0] burst_len = '0;
   logic          fifo_empty;
   logic [DW-1:0] fifo_rdata;
   logic          fifo_rd;
   logic          bus_ready = 1'b1;
   logic          bus_sel, bus_stb, bus_wr, bus_last;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;

   logic [DW-1:0] mem [64];
   int rp = 0, wp = 0;
   int total = 0, bad = 0, cyc = 0;
   int rdy_k = 0, gap = 0, npush = 0, pushed = 0;
   bit rd_pend = 0, sel_prev = 0, stall_pend = 0, wd_hit = 0;
   logic [DW-1:0] prev_data;
   logic prev_last;
   int nrise, nw, addr_cyc, first_cyc, last_cyc, nlast, last_idx;
   int underflow, stall_viol, bad_addr_ph;
   logic [AW-1:0] addr_seen;
   logic [DW-1:0] got [64];

   assign fifo_empty = (rp == wp);
   assign fifo_rdata = mem[rp[5:0]];

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_wr_ctrl #(.DW(DW), .AW(AW), .LW(LW)) i_burst_wr_ctrl (
      .clk(clk), .rst_n(rst_n), .go(go), .base_addr(base_addr),
      .burst_len(burst_len), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
      .fifo_rd(fifo_rd), .bus_ready(bus_ready), .bus_sel(bus_sel),
      .bus_stb(bus_stb), .bus_wr(bus_wr), .bus_last(bus_last),
      .bus_addr(bus_addr), .bus_data(bus_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] word_of(input int run, input int i);
      return 32'h5A00_0000 + DW'(run << 12) + DW'(i);
   endfunction

   task automatic push(input logic [DW-1:0] w);
      mem[wp[5:0]] = w;
      wp++;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // one cycle: update inputs after the falling edge, then observe
   task automatic step(input int run);
      @(negedge clk);
      cyc++;
      if (rd_pend) rp++;
      if (gap != 0 && pushed < npush && (cyc % gap) == 0) begin
         push(word_of(run, pushed));
         pushed++;
      end
      bus_ready = (rdy_k == 0) ? 1'b1 : ((cyc % rdy_k) != 0);
      #1;
      if (bus_sel && !sel_prev) begin
         nrise++;
         addr_seen = bus_addr;
         addr_cyc  = cyc;
         if (!bus_stb || !bus_wr) bad_addr_ph++;
      end else if (bus_sel && bus_stb) begin
         if (stall_pend && (bus_data !== prev_data || bus_last !== prev_last))
            stall_viol++;
         if (bus_ready) begin
            if (nw < 64) got[nw] = bus_data;
            if (bus_last) begin nlast++; last_idx = nw; end
            if (nw == 0) first_cyc = cyc;
            last_cyc = cyc;
            nw++;
            stall_pend = 0;
         end else begin
            stall_pend = 1;
            prev_data  = bus_data;
            prev_last  = bus_last;
         end
      end
      if (fifo_rd && fifo_empty) underflow++;
      rd_pend  = fifo_rd;
      sel_prev = bus_sel;
      if (cyc > 150000 && !wd_hit) begin
         wd_hit = 1;
         chk(0, "WDOG", "watchdog expired", cyc, 150000);
         finish_run();
      end
   endtask

   task automatic run_burst(input int run, input int len, input int rk,
                            input int g, input int addr);
      int eff;
      bit fast;
      eff = (len == 0) ? 1 : len;
      fast = (rk == 0 && g == 0);
      rp = 0; wp = 0; rd_pend = 0; pushed = 0; npush = eff;
      nrise = 0; nw = 0; nlast = 0; last_idx = -1; underflow = 0;
      stall_viol = 0; bad_addr_ph = 0; stall_pend = 0;
      rdy_k = rk; gap = g;
      if (g == 0) begin
         for (int i = 0; i < eff; i++) push(word_of(run, i));
         pushed = eff;
      end
      base_addr = AW'(addr);
      burst_len = LW'(len);
      go = 1'b1;
      for (int k = 0; k < 3000; k++) begin
         step(run);
         if (nrise > 0 && !bus_sel) break;
      end
      base_addr = '0;
      chk(addr_seen == AW'(addr), "R3", "start address", addr_seen, addr);
      chk(bad_addr_ph == 0, "R3", "address phase strobe/write", bad_addr_ph, 0);
      chk(nrise == 1, "R7", "address phases per burst", nrise, 1);
      chk(nw == eff, "R4", "word count", nw, eff);
      for (int i = 0; i < eff && i < nw; i++)
         if (got[i] !== word_of(run, i))
            chk(0, "R4", "word order", got[i], word_of(run, i));
      chk(underflow == 0, "R4", "pop while empty", underflow, 0);
      chk(nlast == 1 && last_idx == eff - 1, "R8", "last flag position",
          last_idx, eff - 1);
      chk(stall_viol == 0, "R6", "stalled word held", stall_viol, 0);
      if (fast) begin
         chk(first_cyc - addr_cyc == 3, "R5", "lead-in cycles",
             first_cyc - addr_cyc, 3);
         chk(last_cyc - first_cyc == eff - 1, "R5", "back-to-back span",
             last_cyc - first_cyc, eff - 1);
      end
      // R9: go still high, no restart
      for (int k = 0; k < 6; k++) begin
         step(run);
         chk(!bus_sel && !fifo_rd, "R9", "idle while go high", bus_sel, 0);
      end
      go = 1'b0;
      step(run);
      step(run);
   endtask

   initial begin
      go = 1'b1;  // held through reset: must not start (R2)
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!bus_sel && !bus_stb && !bus_wr && !bus_last && !fifo_rd, "R1",
             "outputs in reset", {bus_sel, bus_stb, bus_wr, bus_last, fifo_rd}, 0);
      end
      rst_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
         step(0);
         chk(!bus_sel && !bus_stb && !fifo_rd, "R2", "level go does not start",
             bus_sel, 0);
      end
      chk(!bus_wr && !bus_last, "R1", "write/last idle after reset",
          {bus_wr, bus_last}, 0);
      go = 1'b0;
      step(0);
      step(0);

      for (int v = 0; v < NVEC; v++)
         run_burst(v + 1, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

      // zero length behaves as one word (R4)
      run_burst(20, 0, 0, 0, 'h055);
      // zero length with a stalling bus
      run_burst(21, 0, 2, 0, 'h066);
      // restart after release works again (R9)
      run_burst(22, 5, 0, 2, 'h077);

      finish_run();
   end
endmodule